// File: doc/BRIEF.md
# SMBus Master Byte FIFO with Thresholds

This block sits between a byte-wide register port and the byte engine of an SMBus master. It holds up to 16 queued transmit bytes and 16 received bytes. It tracks their counts against programmable thresholds and raises sticky threshold flags and an interrupt. On receive, it can tell the engine to NACK the final byte of a burst. It also works out whether a data byte is ready (SDAST) for the status logic while queueing is enabled.

The register port is a plain strobe interface. `cfg_wr` and `cfg_rd` are single-cycle strobes that are never asserted together, and `cfg_rdata` is combinational from `cfg_addr`. Towards the engine there are two valid/ready byte streams:

- **Transmit stream.** The block drives `tx_valid`/`tx_data` and pops one byte in every cycle in which `tx_valid && tx_ready`. `tx_data` is held stable while the engine applies back-pressure.
- **Receive stream.** The engine drives `rx_valid`/`rx_data`. The block accepts a byte in every cycle in which `rx_valid && rx_ready`. It drops `rx_ready` when the receive queue is full or when a final byte has been taken. The engine must keep its byte until it is accepted. `rx_nack` is meaningful in the cycle of acceptance and says that byte is to be NACKed on the bus.

Register map:

| Address | Contents |
|---|---|
| 0 | Data: a write queues a transmit byte, a read pops a received byte |
| 1 | Mode: bit 4 enables queueing |
| 2 | Control-status: bit 6 clears both queues, bit 3 is the threshold-event interrupt enable, bit 1 is the transmit-threshold event flag |
| 3 | Transmit control: bit 6 is the interrupt enable, bits 4:0 are the threshold |
| 4 | Transmit status: bit 7 is overflow, bit 6 is the threshold flag, bits 4:0 are the count |
| 5 | Receive control: bit 6 is the interrupt enable, bit 5 marks the final byte, bits 4:0 are the threshold |
| 6 | Receive status: bit 6 is the threshold flag, bits 4:0 are the count |
| 7 | Reads 0 |

Top module: `smbus_fifo`

## Requirements
- R1: After reset every register address 0..7 reads 0x00, `tx_valid`, `sdast` and `irq` are 0.
- R2: While mode bit 4 is 0, data writes are ignored (transmit count stays 0, no overflow), `tx_valid` is 0 and `rx_ready` is 0.
- R3: Bytes written to address 0 appear on the transmit stream in write order, one per handshake cycle, and address 4 bits 4:0 report how many are still queued.
- R4: When a transmit pop brings the count equal to the threshold (address 3 bits 4:0), address 4 bit 6 sets and stays set until 1 is written to it; `irq` is high while it and address 3 bit 6 are both 1.
- R5: A data write with 16 bytes queued is ignored: the count stays 16, the queued bytes are unchanged, and address 4 bit 7 sets until 1 is written to it.
- R6: Received bytes are read from address 0 in arrival order; each such read pops one byte and decrements address 6 bits 4:0; `rx_ready` is 0 when 16 bytes are held.
- R7: When an accepted receive byte brings the count equal to address 5 bits 4:0, address 6 bit 6 sets (cleared by writing 1); `irq` is high while it and address 5 bit 6 are both 1.
- R8: With address 5 bit 5 set, the byte that brings the receive count to the threshold is accepted with `rx_nack` = 1, after which `rx_ready` stays 0 until address 5 is written.
- R9: Reading address 0 with the receive queue empty returns the most recently popped byte and changes nothing.
- R10: With queueing enabled, `sdast` is: in transmit mode (`xmit_mode` = 1), queue not full; in receive mode with address 5 bit 6 set, exactly 16 bytes held; in receive mode otherwise, at least one byte held. With queueing off it is 0.
- R11: Writing address 2 with bit 6 set empties both queues and clears address 4 and address 6 to 0 and address 2 bit 1 to 0; bit 6 always reads 0.
- R12: Address 2 bit 1 sets together with the transmit threshold flag, is cleared by writing 1 to it, and drives `irq` while address 2 bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (pops on address 0) |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data, combinational |
| xmit_mode | input | 1 | Engine direction, 1 = transmit |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Engine takes the transmit byte |
| tx_data | output | 8 | Transmit byte at queue head |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_ready | output | 1 | Block can accept a received byte |
| rx_data | input | 8 | Received byte |
| rx_nack | output | 1 | Byte accepted now is the final one and must be NACKed |
| sdast | output | 1 | Data-ready status for the status register |
| irq | output | 1 | Threshold interrupt |

## Verification
The bench fills the transmit queue past 16 and checks that the 17th byte is dropped without corrupting the stream. A design that wrapped its pointers would emit a stale or overwritten byte, and one that counted the write would report 17. It drains the transmit queue to a non-zero threshold and checks that the flag stays set after the count moves past it, which catches a level-compare in place of a sticky event. On receive it checks the final-byte NACK on exactly the threshold byte and the halt after it: an off-by-one would NACK early or late, and a missing halt would let a third byte in. It also checks the data-ready masking at 15 versus 16 held bytes, the empty read that returns the last byte, and that a clear leaves every status register at zero.

// File: rtl/smbus_fifo_pkg.sv
package smbus_fifo_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int THR_W  = 5;

  localparam logic [ADDR_W-1:0] RA_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] RA_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] RA_FCS   = 3'd2;
  localparam logic [ADDR_W-1:0] RA_TXCTL = 3'd3;
  localparam logic [ADDR_W-1:0] RA_TXSTS = 3'd4;
  localparam logic [ADDR_W-1:0] RA_RXCTL = 3'd5;
  localparam logic [ADDR_W-1:0] RA_RXSTS = 3'd6;

  localparam int B_FEN   = 4;
  localparam int B_CLR   = 6;
  localparam int B_RFTE  = 3;
  localparam int B_EVT   = 1;
  localparam int B_IE    = 6;
  localparam int B_THST  = 6;
  localparam int B_LAST  = 5;
  localparam int B_OVF   = 7;
endpackage

// File: rtl/smbus_fifo_queue.sv
module smbus_fifo_queue #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign push_ok = push && (count != FULL_CNT);
  assign pop_ok  = pop && (count != '0);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/smbus_fifo_flags.sv
module smbus_fifo_flags #(
  parameter int DEPTH = 16,
  parameter int THR_W = 5,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             fifo_en,
  input  logic             xmit_mode,
  input  logic             thr_rxie,
  input  logic             last_en,
  input  logic [THR_W-1:0] rx_thr,
  input  logic [CW-1:0]    tx_cnt,
  input  logic [CW-1:0]    rx_cnt,
  output logic             sdast,
  output logic             rx_nack
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam int SW = ((CW > THR_W) ? CW : THR_W) + 1;

  logic [SW-1:0] rx_after;

  assign rx_after = SW'(rx_cnt) + SW'(1);
  assign rx_nack  = fifo_en && last_en && (rx_after >= SW'(rx_thr));

  always_comb begin
    if (!fifo_en)       sdast = 1'b0;
    else if (xmit_mode) sdast = (tx_cnt != FULL_CNT);
    else if (thr_rxie)  sdast = (rx_cnt == FULL_CNT);
    else                sdast = (rx_cnt != '0);
  end
endmodule

// File: rtl/smbus_fifo.sv
module smbus_fifo
  import smbus_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              xmit_mode,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_nack,
  output logic              sdast,
  output logic              irq
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic             fifo_en, rfte_ie, rxf_txe;
  logic             thr_txie, tx_thst, tx_ovf;
  logic             thr_rxie, last_en, rx_thst, rx_done;
  logic [THR_W-1:0] tx_thr, rx_thr;
  logic [DATA_W-1:0] last_pop, rx_head;
  logic [CW-1:0]    tx_cnt, rx_cnt, tx_cnt_nxt, rx_cnt_nxt;

  logic wr_data, wr_mode, wr_fcs, wr_txctl, wr_txsts, wr_rxctl, wr_rxsts;
  logic clr, tx_push, tx_pop, tx_ovf_evt, rx_push, rx_pop, tx_hit, rx_hit;

  assign wr_data  = cfg_wr && (cfg_addr == RA_DATA);
  assign wr_mode  = cfg_wr && (cfg_addr == RA_MODE);
  assign wr_fcs   = cfg_wr && (cfg_addr == RA_FCS);
  assign wr_txctl = cfg_wr && (cfg_addr == RA_TXCTL);
  assign wr_txsts = cfg_wr && (cfg_addr == RA_TXSTS);
  assign wr_rxctl = cfg_wr && (cfg_addr == RA_RXCTL);
  assign wr_rxsts = cfg_wr && (cfg_addr == RA_RXSTS);

  assign clr        = wr_fcs && cfg_wdata[B_CLR];
  assign tx_valid   = fifo_en && (tx_cnt != '0);
  assign tx_pop     = tx_valid && tx_ready;
  assign tx_push    = wr_data && fifo_en && (tx_cnt != FULL_CNT);
  assign tx_ovf_evt = wr_data && fifo_en && (tx_cnt == FULL_CNT);
  assign rx_ready   = fifo_en && (rx_cnt != FULL_CNT) && !rx_done;
  assign rx_push    = rx_valid && rx_ready;
  assign rx_pop     = cfg_rd && (cfg_addr == RA_DATA) && (rx_cnt != '0);

  assign tx_cnt_nxt = tx_cnt + CW'(tx_push) - CW'(tx_pop);
  assign rx_cnt_nxt = rx_cnt + CW'(rx_push) - CW'(rx_pop);
  assign tx_hit     = tx_pop && (THR_W'(tx_cnt_nxt) == tx_thr);
  assign rx_hit     = rx_push && (THR_W'(rx_cnt_nxt) == rx_thr);

  smbus_fifo_queue #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(tx_push), .din(cfg_wdata), .pop(tx_pop),
    .head(tx_data), .count(tx_cnt)
  );

  smbus_fifo_queue #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(rx_push), .din(rx_data), .pop(rx_pop),
    .head(rx_head), .count(rx_cnt)
  );

  smbus_fifo_flags #(.DEPTH(DEPTH), .THR_W(THR_W)) u_flags (
    .fifo_en(fifo_en), .xmit_mode(xmit_mode), .thr_rxie(thr_rxie),
    .last_en(last_en), .rx_thr(rx_thr), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .sdast(sdast), .rx_nack(rx_nack)
  );

  // control fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      rfte_ie  <= 1'b0;
      thr_txie <= 1'b0;
      tx_thr   <= '0;
      thr_rxie <= 1'b0;
      last_en  <= 1'b0;
      rx_thr   <= '0;
    end else begin
      if (wr_mode) fifo_en <= cfg_wdata[B_FEN];
      if (wr_fcs)  rfte_ie <= cfg_wdata[B_RFTE];
      if (wr_txctl) begin
        thr_txie <= cfg_wdata[B_IE];
        tx_thr   <= cfg_wdata[THR_W-1:0];
      end
      if (wr_rxctl) begin
        thr_rxie <= cfg_wdata[B_IE];
        last_en  <= cfg_wdata[B_LAST];
        rx_thr   <= cfg_wdata[THR_W-1:0];
      end
    end
  end

  // sticky events: clear beats set, set beats write-one-to-clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thst  <= 1'b0;
      tx_ovf   <= 1'b0;
      rx_thst  <= 1'b0;
      rxf_txe  <= 1'b0;
      rx_done  <= 1'b0;
      last_pop <= '0;
    end else begin
      if (rx_pop) last_pop <= rx_head;
      if (clr) begin
        tx_thst <= 1'b0;
        tx_ovf  <= 1'b0;
        rx_thst <= 1'b0;
        rxf_txe <= 1'b0;
        rx_done <= 1'b0;
      end else begin
        if (tx_hit) tx_thst <= 1'b1;
        else if (wr_txsts && cfg_wdata[B_THST]) tx_thst <= 1'b0;
        if (tx_ovf_evt) tx_ovf <= 1'b1;
        else if (wr_txsts && cfg_wdata[B_OVF]) tx_ovf <= 1'b0;
        if (tx_hit) rxf_txe <= 1'b1;
        else if (wr_fcs && cfg_wdata[B_EVT]) rxf_txe <= 1'b0;
        if (rx_hit) rx_thst <= 1'b1;
        else if (wr_rxsts && cfg_wdata[B_THST]) rx_thst <= 1'b0;
        if (rx_push && rx_nack) rx_done <= 1'b1;
        else if (wr_rxctl) rx_done <= 1'b0;
      end
    end
  end

  assign irq = (thr_txie && tx_thst) || (thr_rxie && rx_thst) || (rfte_ie && rxf_txe);

  always_comb begin
    case (cfg_addr)
      RA_DATA:  cfg_rdata = (rx_cnt != '0) ? rx_head : last_pop;
      RA_MODE:  cfg_rdata = {3'b0, fifo_en, 4'b0};
      RA_FCS:   cfg_rdata = {4'b0, rfte_ie, 1'b0, rxf_txe, 1'b0};
      RA_TXCTL: cfg_rdata = {1'b0, thr_txie, 1'b0, tx_thr};
      RA_TXSTS: cfg_rdata = {tx_ovf, tx_thst, 6'(tx_cnt)};
      RA_RXCTL: cfg_rdata = {1'b0, thr_rxie, last_en, rx_thr};
      RA_RXSTS: cfg_rdata = {1'b0, rx_thst, 6'(rx_cnt)};
      default:  cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/smbus_fifo_chk.sv
module smbus_fifo_chk
  import smbus_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic              cfg_rd,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic              clr_bit,
  input logic              fifo_en,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              rx_nack,
  input logic              irq,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic              tx_thst,
  input logic              rx_thst,
  input logic              rxf_txe
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (!tx_valid && !rx_ready)); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == RA_DATA && tx_cnt == FULL_CNT && !(tx_valid && tx_ready))
    |=> (tx_cnt == FULL_CNT)); // R5

  AST_RX_PUSH_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !(cfg_rd && cfg_addr == RA_DATA))
    |=> (rx_cnt == CW'($past(rx_cnt) + 1'b1))); // R6

  AST_LAST_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_nack) |=> !rx_ready); // R8

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr == RA_FCS && clr_bit)
    |=> (tx_cnt == '0 && rx_cnt == '0 && !tx_thst && !rx_thst && !rxf_txe)); // R11

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tx_thst || rx_thst || rxf_txe)); // R4
endmodule

bind smbus_fifo smbus_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_addr(cfg_addr), .clr_bit(cfg_wdata[smbus_fifo_pkg::B_CLR]),
  .fifo_en(fifo_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_nack(rx_nack), .irq(irq),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_thst(tx_thst), .rx_thst(rx_thst),
  .rxf_txe(rxf_txe)
);

// File: tb/smbus_fifo_bench.sv
module smbus_fifo_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic       xmit_mode = 1'b0;
  logic       tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0, rx_ready;
  logic [7:0] rx_data = '0;
  logic       rx_nack, sdast, irq;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];
  logic [7:0] rv;
  logic       acc, nk;

  smbus_fifo u_smbus_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .xmit_mode(xmit_mode), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_nack(rx_nack), .sdast(sdast), .irq(irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    cfg_addr = a; cfg_rd = 1'b1;
    #1 d = cfg_rdata;
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  // driver: queues a transmit byte and records what must come out
  task automatic tx_put(input logic [7:0] d, input bit expect_out);
    if (expect_out) exp_tx.push_back(d);
    wr(3'd0, d);
  endtask

  task automatic drain(input int n);
    tx_ready = 1'b1;
    repeat (n) @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] d, output logic a, output logic n);
    rx_valid = 1'b1; rx_data = d;
    #1 a = rx_ready; n = rx_nack;
    @(negedge clk);
    rx_valid = 1'b0;
    if (a) exp_rx.push_back(d);
  endtask

  task automatic rx_pop_chk(input string req);
    logic [7:0] got, want;
    rd(3'd0, got);
    if (exp_rx.size() == 0) chk({req, " rx queue empty"}, 1, 0);
    else begin
      want = exp_rx.pop_front();
      chk(req, got, want);
    end
  endtask

  // monitor: compares every transmit handshake with the scoreboard (R3)
  always @(negedge clk) begin
    #2;
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_tx.size() == 0) chk("R3 unexpected tx byte", {24'h0, tx_data}, 32'hFFFF);
      else chk("R3 tx order", tx_data, exp_tx.pop_front());
    end
  end

  initial begin
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), rv);
      chk("R1 reset register", rv, 0);
    end
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 sdast", sdast, 0);
    chk("R1 irq", irq, 0);

    // R2 disabled
    wr(3'd0, 8'h55);
    rd(3'd4, rv); chk("R2 txsts while off", rv, 0);
    chk("R2 tx_valid off", tx_valid, 0);
    chk("R2 rx_ready off", rx_ready, 0);

    // R3 basic transmit
    wr(3'd1, 8'h10);
    rd(3'd1, rv); chk("R3 mode readback", rv, 8'h10);
    for (int i = 0; i < 4; i++) tx_put(8'hA1 + 8'(i), 1'b1);
    rd(3'd4, rv); chk("R3 tx count", rv, 8'h04);
    drain(6);
    chk("R3 all tx bytes out", exp_tx.size(), 0);
    rd(3'd4, rv); chk("R4 thst at zero threshold", rv, 8'h40);
    wr(3'd4, 8'h40);
    wr(3'd2, 8'h02);

    // R4 transmit threshold
    wr(3'd3, 8'h42);
    for (int i = 0; i < 4; i++) tx_put(8'h31 + 8'(i), 1'b1);
    rd(3'd4, rv); chk("R4 no thst before drain", rv, 8'h04);
    chk("R4 irq low before drain", irq, 0);
    drain(2);
    rd(3'd4, rv); chk("R4 thst at threshold", rv, 8'h42);
    chk("R4 irq at threshold", irq, 1);
    rd(3'd2, rv); chk("R12 event flag set", rv, 8'h02);
    drain(4);
    chk("R3 threshold run out", exp_tx.size(), 0);
    rd(3'd4, rv); chk("R4 thst sticky", rv, 8'h40);
    wr(3'd4, 8'h40);
    rd(3'd4, rv); chk("R4 thst w1c", rv, 8'h00);
    chk("R4 irq after clear", irq, 0);

    // R12 event flag interrupt and w1c
    wr(3'd2, 8'h08);
    chk("R12 irq from event", irq, 1);
    wr(3'd2, 8'h0A);
    rd(3'd2, rv); chk("R12 event w1c", rv, 8'h08);
    chk("R12 irq after w1c", irq, 0);
    wr(3'd2, 8'h00);

    // R5 overflow
    wr(3'd3, 8'h00);
    for (int i = 0; i < 17; i++) tx_put(8'h10 + 8'(i), i < 16);
    rd(3'd4, rv); chk("R5 overflow status", rv, 8'h90);
    xmit_mode = 1'b1;
    #1 chk("R10 sdast tx full", sdast, 0);
    drain(18);
    chk("R5 stream intact", exp_tx.size(), 0);
    #1 chk("R10 sdast tx not full", sdast, 1);
    wr(3'd4, 8'hC0);
    rd(3'd4, rv); chk("R5 overflow w1c", rv, 8'h00);
    wr(3'd2, 8'h02);
    xmit_mode = 1'b0;

    // R6 R7 receive with threshold
    wr(3'd5, 8'h43);
    rx_send(8'hB1, acc, nk);
    rx_send(8'hB2, acc, nk);
    rd(3'd6, rv); chk("R7 below threshold", rv, 8'h02);
    chk("R10 sdast masked", sdast, 0);
    chk("R7 irq below threshold", irq, 0);
    rx_send(8'hB3, acc, nk);
    rd(3'd6, rv); chk("R7 threshold reached", rv, 8'h43);
    chk("R7 irq", irq, 1);
    rx_pop_chk("R6 rx byte 1");
    rd(3'd6, rv); chk("R6 count decrement", rv, 8'h42);
    rx_pop_chk("R6 rx byte 2");
    rx_pop_chk("R6 rx byte 3");
    rd(3'd6, rv); chk("R6 count empty", rv, 8'h40);
    rd(3'd0, rv); chk("R9 empty read value", rv, 8'hB3);
    rd(3'd6, rv); chk("R9 empty read no change", rv, 8'h40);
    wr(3'd6, 8'h40);
    chk("R7 irq after w1c", irq, 0);

    // R10 receive full
    wr(3'd5, 8'h40);
    for (int i = 0; i < 15; i++) rx_send(8'hC0 + 8'(i), acc, nk);
    chk("R10 sdast at 15", sdast, 0);
    rx_send(8'hCF, acc, nk);
    chk("R10 sdast at 16", sdast, 1);
    chk("R6 rx_ready full", rx_ready, 0);
    rx_send(8'hEE, acc, nk);
    chk("R6 17th refused", acc, 0);
    wr(3'd5, 8'h00);
    chk("R10 sdast unmasked", sdast, 1);

    // R11 clear
    for (int i = 0; i < 3; i++) tx_put(8'h70 + 8'(i), 1'b0);
    wr(3'd2, 8'h48);
    exp_rx.delete();
    rd(3'd2, rv); chk("R11 clear self-clears", rv, 8'h08);
    rd(3'd4, rv); chk("R11 txsts zero", rv, 8'h00);
    rd(3'd6, rv); chk("R11 rxsts zero", rv, 8'h00);
    chk("R11 tx_valid after clear", tx_valid, 0);
    chk("R11 sdast after clear", sdast, 0);
    wr(3'd2, 8'h00);

    // R8 final byte NACK
    wr(3'd5, 8'h22);
    rx_send(8'hD1, acc, nk);
    chk("R8 first accepted", acc, 1);
    chk("R8 first acked", nk, 0);
    rx_send(8'hD2, acc, nk);
    chk("R8 final accepted", acc, 1);
    chk("R8 final nacked", nk, 1);
    chk("R8 halted", rx_ready, 0);
    rx_send(8'hD3, acc, nk);
    chk("R8 no more requested", acc, 0);
    wr(3'd5, 8'h22);
    chk("R8 resume after write", rx_ready, 1);
    rx_pop_chk("R8 byte 1");
    rx_pop_chk("R8 byte 2");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule